// File: doc/BRIEF.md
# Latched Input Port with Read Handshake

This block is an 8-bit peripheral input port for a small register-mapped interface adapter. A control line carries a byte-ready strobe from the peripheral. On each active (rising) edge of that line, the block raises an interrupt flag. When latching is enabled and the latch is empty, the same edge also captures the port pins into a holding latch. Once the latch is full it keeps its byte, and later strobes do not overwrite it. Only a handshake read frees the latch again.

The CPU reaches the port through a plain register bus with a 4-bit address, one-cycle read and write strobes, and 8-bit data. There are four registers:

- The handshake address (offset 0x1) returns the held byte. A read there also clears the flag and re-arms the latch.
- The raw address (offset 0xF) always returns the live pins and has no side effect.
- A control register (offset 0xB) holds the latch-enable bit.
- A flag register (offset 0xD) shows the strobe flag and clears it on a write of one.

Read data is combinational during the read cycle. All side effects of a read or write take effect at the clock edge that ends that cycle.

Top module: `inport_hs_top`

## Requirements
- R1: After synchronous reset, latching is disabled, the strobe flag is 0, `irq_o` is 0, and reads of offsets 0xB and 0xD return 0x00.
- R2: With latch enable (offset 0xB bit 0) clear, reads at offset 0x1 and offset 0xF both return the pins as they are in the read cycle.
- R3: With latching enabled and the latch empty, a strobe edge captures the pins sampled at that clock edge. A strobe edge is `strobe_i` high at a clock edge after being low at the previous one. Later reads at offset 0x1 return the captured byte.
- R4: While the latch is full, further strobe edges leave the held byte unchanged. After five strobes carrying distinct bytes, offset 0x1 returns the first byte.
- R5: A read at offset 0xF returns the live pins and leaves the flag and the latch-full state unchanged.
- R6: A read at offset 0x1 clears the flag and empties the latch, so the next strobe edge captures a new byte.
- R7: Every strobe edge sets the flag, including when latching is disabled or the latch is full. The flag appears as bit 1 of offset 0xD (all other bits 0), and `irq_o` equals the flag.
- R8: A write to offset 0xB stores data bit 0 as the latch enable, and a read of offset 0xB returns it in bit 0 (other bits 0).
- R9: A write to offset 0xD with data bit 1 set clears the flag. A write with bit 1 clear has no effect on it.
- R10: When a strobe edge falls in the same cycle as a flag-clearing access (handshake read or clearing write), the edge wins. The flag ends set and, for a handshake read, the new pins are captured.
- R11: Read data during the read cycle reflects the state before that read's side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Port pin values |
| strobe_i | input | 1 | Byte-ready control line, rising edge active |
| addr_i | input | 4 | Register offset |
| rd_i | input | 1 | One-cycle read strobe |
| wr_i | input | 1 | One-cycle write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational during the read cycle |
| irq_o | output | 1 | Strobe interrupt flag |

## Verification
A strobe edge can land in the same cycle as a handshake read of offset 0x1, or as a clearing write to offset 0xD. The bench provokes both by raising `strobe_i` in the very cycle that carries the bus access. It first checks that the read data in that cycle still shows the old held byte. It then checks that the flag is still set afterwards. Finally, it checks that the next handshake read returns the pins presented with the coinciding edge, not the byte that was freed.

// File: rtl/inport_hs_pkg.sv
package inport_hs_pkg;
    localparam int DW = 8;
    localparam int AW = 4;

    localparam logic [AW-1:0] OFF_HS   = 4'h1;
    localparam logic [AW-1:0] OFF_CTL  = 4'hB;
    localparam logic [AW-1:0] OFF_FLG  = 4'hD;
    localparam logic [AW-1:0] OFF_RAW  = 4'hF;
    localparam int            FLG_BIT  = 1;
    localparam int            EN_BIT   = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_HS,
        SEL_RAW,
        SEL_CTL,
        SEL_FLG
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e decode(input logic [AW-1:0] a);
        case (a)
            OFF_HS:  return SEL_HS;
            OFF_RAW: return SEL_RAW;
            OFF_CTL: return SEL_CTL;
            OFF_FLG: return SEL_FLG;
            default: return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/inport_hs_edge.sv
module inport_hs_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic edge_o
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b1;
        else     line_q <= line_i;
    end

    assign edge_o = line_i & ~line_q;
endmodule

// File: rtl/inport_hs_latch.sv
module inport_hs_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         edge_i,
    input  logic         rearm_i,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] hold_o,
    output logic         full_o
);
    logic [W-1:0] hold_q;
    logic         full_q;
    logic         free;

    // latch is free if empty, or being released in this very cycle
    assign free = ~full_q | rearm_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (edge_i && en_i && free) begin
            hold_q <= pins_i;
            full_q <= 1'b1;
        end else if (rearm_i) begin
            full_q <= 1'b0;
        end
    end

    assign hold_o = hold_q;
    assign full_o = full_q;

    // R4
    hold_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (full_q && !rearm_i) |=> ($stable(hold_q) && full_q));

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_i && en_i && !full_q) |=> (full_q && hold_q == $past(pins_i)));
endmodule

// File: rtl/inport_hs_flag.sv
module inport_hs_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/inport_hs_top.sv
module inport_hs_top
    import inport_hs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] pins_i,
    input  logic          strobe_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    bus_op_t       op;
    logic          stb_edge;
    logic          en_q;
    logic          flag;
    logic          full;
    logic [DW-1:0] hold;
    logic          hs_read;
    logic          flag_wclr;
    logic          unused_wbits;

    assign op.rd  = rd_i;
    assign op.wr  = wr_i;
    assign op.sel = decode(addr_i);

    assign hs_read   = op.rd && op.sel == SEL_HS;
    assign flag_wclr = op.wr && op.sel == SEL_FLG && wdata_i[FLG_BIT];
    assign unused_wbits = ^wdata_i[DW-1:2];

    inport_hs_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (strobe_i),
        .edge_o (stb_edge)
    );

    inport_hs_latch #(.W(DW)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_q),
        .edge_i  (stb_edge),
        .rearm_i (hs_read),
        .pins_i  (pins_i),
        .hold_o  (hold),
        .full_o  (full)
    );

    inport_hs_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (stb_edge),
        .clr_i  (hs_read | flag_wclr),
        .flag_o (flag)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (op.wr && op.sel == SEL_CTL)
            en_q <= wdata_i[EN_BIT];
    end

    always_comb begin
        rdata_o = '0;
        case (op.sel)
            SEL_HS:  rdata_o = en_q ? hold : pins_i;
            SEL_RAW: rdata_o = pins_i;
            SEL_CTL: rdata_o[EN_BIT] = en_q;
            SEL_FLG: rdata_o[FLG_BIT] = flag;
            default: rdata_o = '0;
        endcase
    end

    assign irq_o = flag;

    // R5
    raw_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !wr_i && op.sel == SEL_RAW && !stb_edge) |=> ($stable(flag) && $stable(full)));

    // R10
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_edge && (hs_read || flag_wclr)) |=> irq_o);
endmodule

// File: tb/sim_inport_hs_top.sv
module sim_inport_hs_top;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pins = 8'h00;
    logic       strobe = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(PER/2) clk = ~clk;

    inport_hs_top u0 (
        .clk(clk), .rst(rst), .pins_i(pins), .strobe_i(strobe),
        .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // monitor: compares read data a quarter period after the driving edge
    always @(negedge clk) begin
        #(PER/4);
        if (rd && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: rdata=%02h expected=%02h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; rd = 1'b1;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk);
        pins = v; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        #(PER/4);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq=%0b expected=%0b", tag, irq, e);
        end
    endtask

    initial begin
        #(PER * 100000);
        errors++;
        $display("FAIL watchdog: run=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        item_t it;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        rd_chk(4'hD, 8'h00, "R1 flag reg");
        rd_chk(4'hB, 8'h00, "R1 ctl reg");
        irq_chk(1'b0, "R1 irq");
        // R2
        pins = 8'h3C;
        rd_chk(4'h1, 8'h3C, "R2 hs addr live");
        rd_chk(4'hF, 8'h3C, "R2 raw addr live");
        pulse(8'h11);
        pins = 8'h77;
        rd_chk(4'h1, 8'h77, "R2 live after strobe");
        // R7 flag set even without capture (the R2 read above cleared it, strobe again)
        pulse(8'h12);
        rd_chk(4'hD, 8'h02, "R7 flag without capture");
        irq_chk(1'b1, "R7 irq");
        // R9
        wr_reg(4'hD, 8'hFD);
        rd_chk(4'hD, 8'h02, "R9 write bit1=0 keeps");
        wr_reg(4'hD, 8'h02);
        rd_chk(4'hD, 8'h00, "R9 write bit1=1 clears");
        // R8
        wr_reg(4'hB, 8'hFF);
        rd_chk(4'hB, 8'h01, "R8 enable readback");
        // R3 / R4: five strobes
        pulse(8'hA1);
        rd_chk(4'hD, 8'h02, "R7 flag after capture");
        pulse(8'hA2);
        pulse(8'hA3);
        pulse(8'hA4);
        pulse(8'hA5);
        // R5
        rd_chk(4'hF, 8'hA5, "R5 raw returns fifth");
        rd_chk(4'hD, 8'h02, "R5 flag kept after raw read");
        pins = 8'h99;
        rd_chk(4'h1, 8'hA1, "R4 hs returns first");
        rd_chk(4'hD, 8'h00, "R6 flag cleared by hs read");
        irq_chk(1'b0, "R6 irq low");
        // R6 re-arm
        pulse(8'h5C);
        pins = 8'h00;
        rd_chk(4'h1, 8'h5C, "R6 rearmed capture");
        // R10 / R11: latch full with 0x6A, then hs read coincides with edge carrying 0xC3
        pulse(8'h6A);
        @(negedge clk);
        pins = 8'hC3; strobe = 1'b1; addr = 4'h1; rd = 1'b1;
        it.exp = 8'h6A; it.tag = "R11 old byte during read";
        sb.push_back(it);
        @(negedge clk);
        rd = 1'b0; strobe = 1'b0; pins = 8'h00;
        rd_chk(4'hD, 8'h02, "R10 flag survives hs read");
        rd_chk(4'h1, 8'hC3, "R10 new byte captured");
        // R10: clearing write coincides with edge
        @(negedge clk);
        strobe = 1'b1; addr = 4'hD; wdata = 8'h02; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; strobe = 1'b0;
        rd_chk(4'hD, 8'h02, "R10 flag survives write clear");
        // R1 again after mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk(4'hB, 8'h00, "R1 ctl after reset");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule